// File: doc/BRIEF.md
# Receive Lane Parallel Output Multiplexer

This block sits between the receive half of a serial link and the output pads of the parallel receive bus. Each recovered-clock cycle it takes the decoded low and high bytes with their control-code flags, a pattern-checker pass flag and a loss-of-signal flag. From the mode pins it decides what the 16-bit data bus and the two per-byte control-code indicators carry, and whether each pad group drives or floats. It also drives an enable and a pass/hold-low control for the recovered-clock output pad.

The mode pins are resolved by a fixed priority. From highest to lowest: power-on reset, power-down (enable low), lock-to-reference, loss of signal, pattern test, normal data. The loss-of-signal and pass flags come from circuits with their own timing, so each goes through `SYNC_STAGES` flops before it reaches the outputs. The decoded bytes arrive on plain pins, one word in every cycle. There is no valid/ready pair, because the pads cannot apply back-pressure: a word that is presented is sampled at the next rising edge and shown one cycle later, and the bus never stalls.

Top module: `rx_lane_outmux`

## Requirements
- R1: In normal mode (all modes inactive), one clock after sampling, `rxd` = {`byte_hi`,`byte_lo`}, `k_lo` = `kflag_lo`, `k_hi` = `kflag_hi`, every output enable is 1 and `clk_pass` is 1.
- R2: With `prbs_en` high and no higher mode, `k_lo` shows the synchronised `prbs_pass` (1 = pass) instead of `kflag_lo`, while `rxd` and `k_hi` stay as in R1.
- R3: While the synchronised loss-of-signal flag is 1 and no higher mode is active, `rxd` is 16'hFFFF and both indicators are 1, whatever `prbs_en` is.
- R4: With `rx_en` low (and no power-on reset), only `k_hi_oe` is 1 and `k_hi` is the inverse of the synchronised loss-of-signal flag (0 = signal lost). `rxd`, `k_lo`, `clk_oe` and `clk_pass` are 0.
- R5: With `rx_en` high and `lockref_n` low, every enable including `clk_oe` is 0, and `rxd`, `k_lo` and `k_hi` are 0, even while signal is lost.
- R6: With `por_active` high, the data and indicator enables are 0, `clk_oe` is 1 and `clk_pass` is 0 (clock held low), whatever the other mode pins are.
- R7: A change of `los_in` or `prbs_pass` reaches the outputs on the third rising edge after it, and not on the second (default of two sync stages).
- R8: While `rst_n` is low, all outputs are 0.
- R9: Power-down outranks lock-to-reference: with both `rx_en` and `lockref_n` low, R4 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock (serial bit rate / 20) |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_active | input | 1 | Power-on reset in progress |
| rx_en | input | 1 | Device enable; low selects power-down |
| lockref_n | input | 1 | Low selects lock-to-reference (receive outputs float) |
| prbs_en | input | 1 | Pattern test mode |
| los_in | input | 1 | Loss of signal, asynchronous |
| prbs_pass | input | 1 | Pattern checker pass, asynchronous |
| byte_lo | input | 8 | Decoded low byte |
| byte_hi | input | 8 | Decoded high byte |
| kflag_lo | input | 1 | Low byte is a control code |
| kflag_hi | input | 1 | High byte is a control code |
| rxd | output | 16 | Receive data bus value |
| k_lo | output | 1 | Low-byte control indicator / pattern result |
| k_hi | output | 1 | High-byte control indicator / signal status |
| rxd_oe | output | 1 | Drive enable for the data pads |
| k_lo_oe | output | 1 | Drive enable for the low indicator pad |
| k_hi_oe | output | 1 | Drive enable for the high indicator pad |
| clk_oe | output | 1 | Drive enable for the clock output pad |
| clk_pass | output | 1 | 1 passes the recovered clock, 0 holds the pad low |

## Verification
Loss of signal and the pattern test claim the low indicator at the same time. The bench raises `los_in` and, once the forced value has appeared, sets `prbs_en` with the pass flag low. `k_lo` must stay 1 and `rxd` must stay all ones, and the pass result must return three edges after `los_in` drops. In the same way, the bench raises loss of signal while lock-to-reference or power-down is active and checks that the higher mode alone sets the enables.

// File: rtl/rx_lane_outmux_pkg.sv
package rx_lane_outmux_pkg;
  typedef enum logic [2:0] {
    MODE_POR    = 3'd0,
    MODE_PDN    = 3'd1,
    MODE_REFLK  = 3'd2,
    MODE_LOS    = 3'd3,
    MODE_PRBS   = 3'd4,
    MODE_DATA   = 3'd5
  } out_mode_e;

  typedef struct packed {
    logic rxd_oe;
    logic k_lo_oe;
    logic k_hi_oe;
    logic clk_oe;
    logic clk_pass;
  } pad_ctl_t;
endpackage

// File: rtl/rx_lane_sync.sv
module rx_lane_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_lane_mode_sel.sv
module rx_lane_mode_sel
  import rx_lane_outmux_pkg::*;
(
  input  logic      por_active,
  input  logic      rx_en,
  input  logic      lockref_n,
  input  logic      los_s,
  input  logic      prbs_en,
  output out_mode_e mode
);
  always_comb begin
    if (por_active)      mode = MODE_POR;
    else if (!rx_en)     mode = MODE_PDN;
    else if (!lockref_n) mode = MODE_REFLK;
    else if (los_s)      mode = MODE_LOS;
    else if (prbs_en)    mode = MODE_PRBS;
    else                 mode = MODE_DATA;
  end
endmodule

// File: rtl/rx_lane_out_stage.sv
module rx_lane_out_stage
  import rx_lane_outmux_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  out_mode_e         mode,
  input  logic [BYTE_W-1:0] byte_lo,
  input  logic [BYTE_W-1:0] byte_hi,
  input  logic              kflag_lo,
  input  logic              kflag_hi,
  input  logic              los_s,
  input  logic              pass_s,
  output logic [DW-1:0]     rxd,
  output logic              k_lo,
  output logic              k_hi,
  output pad_ctl_t          pads
);
  logic [DW-1:0] rxd_d;
  logic          k_lo_d, k_hi_d;
  pad_ctl_t      pads_d;

  always_comb begin
    rxd_d  = '0;
    k_lo_d = 1'b0;
    k_hi_d = 1'b0;
    pads_d = '0;
    unique case (mode)
      MODE_POR: begin
        pads_d.clk_oe = 1'b1;
      end
      MODE_PDN: begin
        pads_d.k_hi_oe = 1'b1;
        k_hi_d         = ~los_s;
      end
      MODE_REFLK: begin
        pads_d = '0;
      end
      MODE_LOS: begin
        pads_d = '1;
        rxd_d  = '1;
        k_lo_d = 1'b1;
        k_hi_d = 1'b1;
      end
      MODE_PRBS: begin
        pads_d = '1;
        rxd_d  = {byte_hi, byte_lo};
        k_lo_d = pass_s;
        k_hi_d = kflag_hi;
      end
      default: begin
        pads_d = '1;
        rxd_d  = {byte_hi, byte_lo};
        k_lo_d = kflag_lo;
        k_hi_d = kflag_hi;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd  <= '0;
      k_lo <= 1'b0;
      k_hi <= 1'b0;
      pads <= '0;
    end else begin
      rxd  <= rxd_d;
      k_lo <= k_lo_d;
      k_hi <= k_hi_d;
      pads <= pads_d;
    end
  end
endmodule

// File: rtl/rx_lane_outmux.sv
module rx_lane_outmux
  import rx_lane_outmux_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_active,
  input  logic              rx_en,
  input  logic              lockref_n,
  input  logic              prbs_en,
  input  logic              los_in,
  input  logic              prbs_pass,
  input  logic [BYTE_W-1:0] byte_lo,
  input  logic [BYTE_W-1:0] byte_hi,
  input  logic              kflag_lo,
  input  logic              kflag_hi,
  output logic [DW-1:0]     rxd,
  output logic              k_lo,
  output logic              k_hi,
  output logic              rxd_oe,
  output logic              k_lo_oe,
  output logic              k_hi_oe,
  output logic              clk_oe,
  output logic              clk_pass
);
  logic      los_sync, pass_sync;
  out_mode_e mode;
  pad_ctl_t  pads;

  rx_lane_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({los_in, prbs_pass}),
    .q     ({los_sync, pass_sync})
  );

  rx_lane_mode_sel u_mode (
    .por_active (por_active),
    .rx_en      (rx_en),
    .lockref_n  (lockref_n),
    .los_s      (los_sync),
    .prbs_en    (prbs_en),
    .mode       (mode)
  );

  rx_lane_out_stage #(.BYTE_W(BYTE_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .byte_lo  (byte_lo),
    .byte_hi  (byte_hi),
    .kflag_lo (kflag_lo),
    .kflag_hi (kflag_hi),
    .los_s    (los_sync),
    .pass_s   (pass_sync),
    .rxd      (rxd),
    .k_lo     (k_lo),
    .k_hi     (k_hi),
    .pads     (pads)
  );

  assign rxd_oe   = pads.rxd_oe;
  assign k_lo_oe  = pads.k_lo_oe;
  assign k_hi_oe  = pads.k_hi_oe;
  assign clk_oe   = pads.clk_oe;
  assign clk_pass = pads.clk_pass;
endmodule

// File: rtl/rx_lane_outmux_chk.sv
module rx_lane_outmux_chk #(
  parameter int BYTE_W = 8,
  localparam int DW = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_active,
  input logic              rx_en,
  input logic              lockref_n,
  input logic              prbs_en,
  input logic              los_sync,
  input logic              pass_sync,
  input logic [BYTE_W-1:0] byte_lo,
  input logic [BYTE_W-1:0] byte_hi,
  input logic              kflag_lo,
  input logic              kflag_hi,
  input logic [DW-1:0]     rxd,
  input logic              k_lo,
  input logic              k_hi,
  input logic              rxd_oe,
  input logic              k_lo_oe,
  input logic              k_hi_oe,
  input logic              clk_oe,
  input logic              clk_pass
);
  logic live;
  assign live = !por_active && rx_en && lockref_n;

  // R1
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !los_sync && !prbs_en) |=>
      (rxd == $past({byte_hi, byte_lo}) && k_lo == $past(kflag_lo) &&
       k_hi == $past(kflag_hi) && rxd_oe && k_lo_oe && k_hi_oe && clk_oe && clk_pass));

  // R2
  prbs_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !los_sync && prbs_en) |=> (k_lo == $past(pass_sync)));

  // R3
  los_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && los_sync) |=> (rxd == '1 && k_lo && k_hi && rxd_oe));

  // R4
  pdn_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_active && !rx_en) |=>
      (k_hi_oe && !rxd_oe && !k_lo_oe && !clk_oe && k_hi == !$past(los_sync)));

  // R5
  reflock_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_active && rx_en && !lockref_n) |=>
      (!rxd_oe && !k_lo_oe && !k_hi_oe && !clk_oe));

  // R6
  por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_active |=> (!clk_pass && clk_oe && !rxd_oe && !k_lo_oe && !k_hi_oe));
endmodule

bind rx_lane_outmux rx_lane_outmux_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/test_rx_lane_outmux.sv
module test_rx_lane_outmux;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        por_active, rx_en, lockref_n, prbs_en, los_in, prbs_pass;
  logic [7:0]  byte_lo, byte_hi;
  logic        kflag_lo, kflag_hi;
  logic [15:0] rxd;
  logic        k_lo, k_hi, rxd_oe, k_lo_oe, k_hi_oe, clk_oe, clk_pass;
  int          errors = 0;
  int          checks = 0;

  always #5 clk = ~clk;

  rx_lane_outmux i_rx_lane_outmux (
    .clk(clk), .rst_n(rst_n), .por_active(por_active), .rx_en(rx_en),
    .lockref_n(lockref_n), .prbs_en(prbs_en), .los_in(los_in),
    .prbs_pass(prbs_pass), .byte_lo(byte_lo), .byte_hi(byte_hi),
    .kflag_lo(kflag_lo), .kflag_hi(kflag_hi), .rxd(rxd), .k_lo(k_lo),
    .k_hi(k_hi), .rxd_oe(rxd_oe), .k_lo_oe(k_lo_oe), .k_hi_oe(k_hi_oe),
    .clk_oe(clk_oe), .clk_pass(clk_pass)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // enables packed as {rxd_oe,k_lo_oe,k_hi_oe,clk_oe,clk_pass}
  function automatic logic [31:0] en5();
    return {27'd0, rxd_oe, k_lo_oe, k_hi_oe, clk_oe, clk_pass};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; por_active = 1'b0; rx_en = 1'b1; lockref_n = 1'b1;
    prbs_en = 1'b0; los_in = 1'b0; prbs_pass = 1'b0;
    byte_lo = 8'h11; byte_hi = 8'h22; kflag_lo = 1'b1; kflag_hi = 1'b1;
    step(3);
    chk("R8 reset data", {14'd0, k_hi, k_lo, rxd}, 32'h0);
    chk("R8 reset enables", en5(), 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_data();
    byte_lo = 8'hA5; byte_hi = 8'h3C; kflag_lo = 1'b1; kflag_hi = 1'b0;
    step(1);
    chk("R1 word A", {14'd0, k_hi, k_lo, rxd}, {14'd0, 2'b01, 16'h3CA5});
    chk("R1 enables", en5(), 32'h1F);
    byte_lo = 8'h00; byte_hi = 8'hFF; kflag_lo = 1'b0; kflag_hi = 1'b1;
    step(1);
    chk("R1 word B", {14'd0, k_hi, k_lo, rxd}, {14'd0, 2'b10, 16'hFF00});
  endtask

  task automatic t_prbs();
    prbs_pass = 1'b1; prbs_en = 1'b1; kflag_lo = 1'b0; kflag_hi = 1'b0;
    byte_lo = 8'h5A; byte_hi = 8'h69;
    step(3);
    chk("R2 pass shown", {15'd0, k_lo, rxd}, {15'd0, 1'b1, 16'h695A});
    prbs_pass = 1'b0; kflag_lo = 1'b1;
    step(3);
    chk("R2 fail shown", {31'd0, k_lo}, 32'd0);
    prbs_en = 1'b0;
    step(1);
  endtask

  task automatic t_sync_latency();
    byte_lo = 8'h12; byte_hi = 8'h34;
    los_in = 1'b1;
    step(2);
    chk("R7 not yet at edge 2", {16'd0, rxd}, 32'h3412);
    step(1);
    chk("R7 R3 forced at edge 3", {14'd0, k_hi, k_lo, rxd}, {14'd0, 2'b11, 16'hFFFF});
  endtask

  task automatic t_los_vs_prbs();
    prbs_en = 1'b1; prbs_pass = 1'b0; kflag_lo = 1'b0; kflag_hi = 1'b0;
    step(3);
    chk("R3 LOS over PRBS", {15'd0, k_lo, rxd}, {15'd0, 1'b1, 16'hFFFF});
    los_in = 1'b0;
    step(2);
    chk("R7 LOS release edge 2", {16'd0, rxd}, 32'hFFFF);
    step(1);
    chk("R2 result back", {15'd0, k_lo, rxd}, {15'd0, 1'b0, 16'h3412});
    prbs_en = 1'b0;
    step(1);
  endtask

  task automatic t_pdn();
    rx_en = 1'b0;
    step(1);
    chk("R4 enables", en5(), 32'h04);
    chk("R4 values, signal present", {14'd0, k_hi, k_lo, rxd}, {14'd0, 2'b10, 16'h0});
    los_in = 1'b1;
    step(3);
    chk("R4 signal lost", {31'd0, k_hi}, 32'd0);
    lockref_n = 1'b0;
    step(1);
    chk("R9 PDN over refclk", en5(), 32'h04);
    los_in = 1'b0; lockref_n = 1'b1; rx_en = 1'b1;
    step(3);
  endtask

  task automatic t_reflock();
    lockref_n = 1'b0; los_in = 1'b1;
    step(3);
    chk("R5 enables", en5(), 32'h0);
    chk("R5 values", {14'd0, k_hi, k_lo, rxd}, 32'h0);
    lockref_n = 1'b1; los_in = 1'b0;
    step(3);
  endtask

  task automatic t_por();
    por_active = 1'b1; rx_en = 1'b0;
    step(1);
    chk("R6 enables", en5(), 32'h02);
    por_active = 1'b0; rx_en = 1'b1; byte_lo = 8'hC3; byte_hi = 8'h0F;
    step(1);
    chk("R1 after POR", {16'd0, rxd}, 32'h0FC3);
    chk("R1 clk pass after POR", en5(), 32'h1F);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    step(1);
    t_data();
    t_prbs();
    t_sync_latency();
    t_los_vs_prbs();
    t_pdn();
    t_reflock();
    t_por();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule